// File: doc/BRIEF.md
# Multi-Channel Periodic Interrupt Timer

This block is a bank of four independent 32-bit down-counters sitting behind a plain single-cycle register port. Each counter runs in a repeating cycle. It starts from a programmed reload value and counts down by one per clock. When it passes through zero it reloads, raises a sticky event flag and keeps going. Each channel drives its own interrupt line, qualified by a per-channel interrupt enable.

A module-wide disable bit freezes every channel at once. Software may change a channel's reload value at any time without disturbing the period in flight. To abandon the current period and start over from the new value, software turns the channel off and on again. Any channel other than channel 0 can be switched into a cascade mode. In that mode it advances only when its lower neighbour wraps, so two adjacent channels together form a 64-bit timer.

Reads are combinational. `bus_rdata` carries the addressed register while `bus_re` is high and is zero otherwise. Writes take effect on the clock edge where `bus_we` is high.

Top module: `tick_bank`

## Requirements
- R1: After reset every register reads zero, the module-disable bit is clear and every interrupt output is low.
- R2: Register map. The module control register is at 0x000 and its disable bit is bit 1. Channel n occupies 0x100 + 0x10*n, with the reload value at +0x0, the live count at +0x4, control at +0x8 and the event flag at +0xC. Control holds run enable in bit 0, interrupt enable in bit 1 and cascade in bit 2. Any other address reads zero.
- R3: On the first clock after a channel's run enable goes from 0 to 1, its count takes the reload value. After that the count falls by one per clock, so one full period lasts reload + 1 clocks.
- R4: On the clock where a counting channel is at zero, it reloads from the reload register and sets event flag bit 0.
- R5: Writing the reload register while the channel runs leaves the current count path untouched. The new value is first used at the next reload.
- R6: Clearing run enable and then setting it again restarts the channel from the current reload value.
- R7: Writing 1 to flag bit 0 clears it, and writing 0 leaves it unchanged. If a clear lands on the same clock as a hardware set, the flag stays set.
- R8: A channel's interrupt output is high exactly when its event flag and its interrupt enable are both set.
- R9: While the module-disable bit is set, no channel changes its count, including the load that follows a run-enable rise. The bit reads back at bit 1.
- R10: A channel n > 0 with cascade set decrements or reloads only on clocks where channel n-1 reloads from zero. Channel 0 ignores its cascade bit.
- R11: The live count register is read-only, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one clock per write |
| bus_re | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_rdata | output | 32 | Read data, zero when no read is active |
| irq | output | 4 | One interrupt line per channel |

## Verification
Two situations are the hardest to reach from the ports. The first is a software clear of the event flag arriving on the very clock in which the counter wraps and sets it. The bench reaches it with a small reload value and by counting clocks from the enabling write, so that the clearing write lands on the wrap edge. The second is a cascaded channel, whose count only moves on its neighbour's wrap clocks. The bench gives both channels tiny reload values and, on every clock, compares the upper channel's count against the number of lower-channel wraps computed arithmetically. The single-channel behaviour is swept over every channel and a range of reload values, including zero.

// File: rtl/tick_pkg.sv
package tick_pkg;

    localparam int DATA_W     = 32;
    localparam int MCR_ADDR   = 'h000;
    localparam int MDIS_BIT   = 1;
    localparam int CH_BASE    = 'h100;
    localparam int CH_STRIDE  = 'h10;

    // Register slot inside a channel block, selected by address bits [3:2]
    typedef enum logic [1:0] {
        SEL_RELOAD = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_EVENT  = 2'd3
    } reg_sel_e;

    // Channel control word: bit 0 run, bit 1 interrupt enable, bit 2 cascade
    typedef struct packed {
        logic cascade;
        logic ie;
        logic run;
    } chan_ctrl_t;

    function automatic int ch_index_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tick_decode.sv
module tick_decode
    import tick_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 12,
    localparam int IDX_W = ch_index_w(NUM_CH)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              mcr_hit,
    output logic              ch_hit,
    output logic [IDX_W-1:0]  ch_idx,
    output reg_sel_e          sel
);

    logic block_ok;
    logic idx_ok;

    always_comb begin
        mcr_hit  = (addr == ADDR_W'(MCR_ADDR));
        block_ok = (addr[ADDR_W-1:8] == (ADDR_W-8)'(CH_BASE >> 8)) && (addr[1:0] == 2'b00);
        idx_ok   = (32'(addr[7:4]) < NUM_CH);
        ch_hit   = block_ok && idx_ok;
        ch_idx   = addr[4 +: IDX_W];
        sel      = reg_sel_e'(addr[3:2]);
    end

endmodule

// File: rtl/tick_channel.sv
module tick_channel
    import tick_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter bit CAN_CHAIN = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mdis,
    input  logic             wr_reload,
    input  logic             wr_ctrl,
    input  logic             wr_event,
    input  logic [DATA_W-1:0] wdata,
    input  logic             prev_wrap,
    output logic [CNT_W-1:0] reload_q,
    output logic [CNT_W-1:0] count_q,
    output chan_ctrl_t       ctrl_q,
    output logic             event_q,
    output logic             armed_q,
    output logic             wrap_o,
    output logic             irq_o
);

    logic advance;
    logic first_load;
    logic step;

    always_comb begin
        advance    = (CAN_CHAIN && ctrl_q.cascade) ? prev_wrap : 1'b1;
        first_load = ctrl_q.run && !armed_q && !mdis;
        step       = ctrl_q.run && armed_q && !mdis && advance;
        wrap_o     = step && (count_q == '0);
        irq_o      = event_q && ctrl_q.ie;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
            count_q  <= '0;
            ctrl_q   <= '0;
            event_q  <= 1'b0;
            armed_q  <= 1'b0;
        end else begin
            if (wr_reload) begin
                reload_q <= wdata[CNT_W-1:0];
            end
            if (wr_ctrl) begin
                ctrl_q <= chan_ctrl_t'(wdata[2:0]);
            end
            if (!mdis) begin
                armed_q <= ctrl_q.run;
            end
            if (first_load) begin
                count_q <= reload_q;
            end else if (step) begin
                count_q <= (count_q == '0) ? reload_q : count_q - 1'b1;
            end
            if (wrap_o) begin
                event_q <= 1'b1;
            end else if (wr_event && wdata[0]) begin
                event_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/tick_readmux.sv
module tick_readmux
    import tick_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32,
    localparam int IDX_W = ch_index_w(NUM_CH)
) (
    input  logic                          re,
    input  logic                          mcr_hit,
    input  logic                          ch_hit,
    input  logic [IDX_W-1:0]              ch_idx,
    input  reg_sel_e                      sel,
    input  logic                          mdis,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  reload_v,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  count_v,
    input  logic [NUM_CH-1:0][2:0]        ctrl_v,
    input  logic [NUM_CH-1:0]             event_v,
    output logic [DATA_W-1:0]             rdata
);

    always_comb begin
        rdata = '0;
        if (re && mcr_hit) begin
            rdata[MDIS_BIT] = mdis;
        end else if (re && ch_hit) begin
            unique case (sel)
                SEL_RELOAD: rdata = DATA_W'(reload_v[ch_idx]);
                SEL_COUNT:  rdata = DATA_W'(count_v[ch_idx]);
                SEL_CTRL:   rdata = DATA_W'(ctrl_v[ch_idx]);
                SEL_EVENT:  rdata = DATA_W'(event_v[ch_idx]);
                default:    rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/tick_bank.sv
module tick_bank
    import tick_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq
);

    localparam int IDX_W = ch_index_w(NUM_CH);

    logic                         mcr_hit;
    logic                         ch_hit;
    logic [IDX_W-1:0]             ch_idx;
    reg_sel_e                     sel;
    logic                         mdis_q;

    logic [NUM_CH-1:0][CNT_W-1:0] reload_v;
    logic [NUM_CH-1:0][CNT_W-1:0] count_v;
    logic [NUM_CH-1:0][2:0]       ctrl_v;
    logic [NUM_CH-1:0]            event_v;
    logic [NUM_CH-1:0]            armed_v;
    logic [NUM_CH-1:0]            wrap_v;
    logic [NUM_CH-1:0]            prev_v;
    logic [NUM_CH-1:0]            run_v;
    logic [NUM_CH-1:0]            cascade_v;

    tick_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_decode (
        .addr    (bus_addr),
        .mcr_hit (mcr_hit),
        .ch_hit  (ch_hit),
        .ch_idx  (ch_idx),
        .sel     (sel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mdis_q <= 1'b0;
        end else if (bus_we && mcr_hit) begin
            mdis_q <= bus_wdata[MDIS_BIT];
        end
    end

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        logic       hit_n;
        chan_ctrl_t ctrl_n;

        assign hit_n = bus_we && ch_hit && (ch_idx == IDX_W'(n));

        if (n == 0) begin : g_first
            assign prev_v[n] = 1'b0;
        end else begin : g_next
            assign prev_v[n] = wrap_v[n-1];
        end

        tick_channel #(.CNT_W(CNT_W), .CAN_CHAIN(n != 0)) u_chan (
            .clk       (clk),
            .rst       (rst),
            .mdis      (mdis_q),
            .wr_reload (hit_n && (sel == SEL_RELOAD)),
            .wr_ctrl   (hit_n && (sel == SEL_CTRL)),
            .wr_event  (hit_n && (sel == SEL_EVENT)),
            .wdata     (bus_wdata),
            .prev_wrap (prev_v[n]),
            .reload_q  (reload_v[n]),
            .count_q   (count_v[n]),
            .ctrl_q    (ctrl_n),
            .event_q   (event_v[n]),
            .armed_q   (armed_v[n]),
            .wrap_o    (wrap_v[n]),
            .irq_o     (irq[n])
        );

        assign ctrl_v[n]    = ctrl_n;
        assign run_v[n]     = ctrl_n.run;
        assign cascade_v[n] = ctrl_n.cascade;
    end

    tick_readmux #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_readmux (
        .re       (bus_re),
        .mcr_hit  (mcr_hit),
        .ch_hit   (ch_hit),
        .ch_idx   (ch_idx),
        .sel      (sel),
        .mdis     (mdis_q),
        .reload_v (reload_v),
        .count_v  (count_v),
        .ctrl_v   (ctrl_v),
        .event_v  (event_v),
        .rdata    (bus_rdata)
    );

endmodule

// File: rtl/tick_bank_chk.sv
module tick_bank_chk #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         mdis,
    input logic [NUM_CH-1:0][CNT_W-1:0] reload_v,
    input logic [NUM_CH-1:0][CNT_W-1:0] count_v,
    input logic [NUM_CH-1:0]            run_v,
    input logic [NUM_CH-1:0]            cascade_v,
    input logic [NUM_CH-1:0]            armed_v,
    input logic [NUM_CH-1:0]            event_v,
    input logic [NUM_CH-1:0]            wrap_v,
    input logic [NUM_CH-1:0]            irq
);

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
        // R9
        freeze_chk: assert property (@(posedge clk) disable iff (rst)
            mdis |=> $stable(count_v[n]));

        // R3
        arm_load_chk: assert property (@(posedge clk) disable iff (rst)
            (run_v[n] && !armed_v[n] && !mdis) |=> (count_v[n] == $past(reload_v[n])));

        // R4
        flag_src_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(event_v[n]) |-> ($past(count_v[n]) == '0));

        // R8
        irq_flag_chk: assert property (@(posedge clk) disable iff (rst)
            irq[n] |-> event_v[n]);

        if (n == 0) begin : g_free
            // R4
            wrap_reload_chk: assert property (@(posedge clk) disable iff (rst)
                (run_v[n] && armed_v[n] && !mdis && count_v[n] == '0)
                |=> (event_v[n] && count_v[n] == $past(reload_v[n])));
        end else begin : g_casc
            // R10
            cascade_hold_chk: assert property (@(posedge clk) disable iff (rst)
                (run_v[n] && armed_v[n] && cascade_v[n] && !wrap_v[n-1])
                |=> $stable(count_v[n]));
        end
    end

endmodule

bind tick_bank tick_bank_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_tick_bank_chk (
    .clk       (clk),
    .rst       (rst),
    .mdis      (mdis_q),
    .reload_v  (reload_v),
    .count_v   (count_v),
    .run_v     (run_v),
    .cascade_v (cascade_v),
    .armed_v   (armed_v),
    .event_v   (event_v),
    .wrap_v    (wrap_v),
    .irq       (irq)
);

// File: tb/test_tick_bank.sv
module test_tick_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0;
    logic        re = 1'b0;
    logic [31:0] rdata;
    logic [3:0]  irq;

    int errors = 0;
    int checks = 0;

    tick_bank i_tick_bank (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_we    (we),
        .bus_re    (re),
        .bus_rdata (rdata),
        .irq       (irq)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] ra(input int c, input int r);
        return 12'('h100 + 'h10 * c + 4 * r);
    endfunction

    task automatic step(input int k);
        repeat (k) @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk);
        #2;
        we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        addr = a; re = 1'b1;
        #1;
        d = rdata;
        re = 1'b0;
    endtask

    task automatic clr(input int c);
        logic [31:0] v;
        wr(ra(c, 2), 32'd0);
        wr(ra(c, 3), 32'd1);
        rd(ra(c, 3), v);
        chk($sformatf("R7 clear ch%0d", c), v, 32'd0);
        chk($sformatf("R8 irq low ch%0d", c), 32'(irq[c]), 32'd0);
    endtask

    task automatic sweep(input int c, input int lv, input bit ie);
        logic [31:0] v;
        logic [31:0] ctl;
        ctl = 32'(1 | (int'(ie) << 1) | ((c == 0) ? 4 : 0));
        wr(ra(c, 0), 32'(lv));
        wr(ra(c, 2), ctl);
        for (int j = 0; j <= 2 * lv + 3; j++) begin
            step(1);
            rd(ra(c, 1), v);
            chk($sformatf("R3 R10 count ch%0d L=%0d j=%0d", c, lv, j), v, 32'(lv - (j % (lv + 1))));
            rd(ra(c, 3), v);
            chk($sformatf("R4 flag ch%0d L=%0d j=%0d", c, lv, j), v, 32'(j >= lv + 1));
            chk($sformatf("R8 irq ch%0d L=%0d j=%0d", c, lv, j), 32'(irq[c]), 32'((j >= lv + 1) && ie));
        end
        clr(c);
    endtask

    task automatic cascade(input int n, input int l0, input int l1);
        logic [31:0] v;
        int w;
        wr(ra(n - 1, 0), 32'(l0));
        wr(ra(n, 0), 32'(l1));
        wr(ra(n, 2), 32'h5);
        wr(ra(n - 1, 2), 32'h1);
        for (int j = 0; j <= (l0 + 1) * (l1 + 2); j++) begin
            step(1);
            w = j / (l0 + 1);
            rd(ra(n, 1), v);
            chk($sformatf("R10 cascade count ch%0d j=%0d", n, j), v, 32'(l1 - (w % (l1 + 1))));
            rd(ra(n, 3), v);
            chk($sformatf("R10 cascade flag ch%0d j=%0d", n, j), v, 32'(w >= l1 + 1));
        end
        clr(n - 1);
        clr(n);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] p1;
        step(3);
        rst = 1'b0;

        // R1 reset state
        rd(12'h000, v);
        chk("R1 module control", v, 32'd0);
        chk("R1 irq", 32'(irq), 32'd0);
        for (int c = 0; c < 4; c++) begin
            for (int r = 0; r < 4; r++) begin
                rd(ra(c, r), v);
                chk($sformatf("R1 ch%0d reg%0d", c, r), v, 32'd0);
            end
            step(1);
        end

        // R2 unmapped addresses and control readback
        rd(12'h004, v);
        chk("R2 unmapped 0x004", v, 32'd0);
        rd(12'h140, v);
        chk("R2 unmapped 0x140", v, 32'd0);
        wr(ra(3, 2), 32'h6);
        rd(ra(3, 2), v);
        chk("R2 control readback", v, 32'h6);
        wr(ra(3, 2), 32'h0);

        // R3 R4 R8 sweep over every channel and small reload values
        for (int c = 0; c < 4; c++) begin
            for (int lv = 0; lv < 6; lv++) begin
                sweep(c, lv, (lv % 2) == 0);
            end
        end

        // R2 R3 full-width reload value
        wr(ra(0, 0), 32'hFFFF_FFFF);
        rd(ra(0, 0), v);
        chk("R2 reload readback", v, 32'hFFFF_FFFF);
        wr(ra(0, 2), 32'h1);
        step(1);
        rd(ra(0, 1), v);
        chk("R3 full-width load", v, 32'hFFFF_FFFF);
        step(1);
        rd(ra(0, 1), v);
        chk("R3 full-width decrement", v, 32'hFFFF_FFFE);
        clr(0);

        // R5 reload change while running
        wr(ra(1, 0), 32'd10);
        wr(ra(1, 2), 32'h1);
        step(4);
        wr(ra(1, 0), 32'd3);
        rd(ra(1, 1), v);
        chk("R5 count unaffected", v, 32'd6);
        rd(ra(1, 0), v);
        chk("R5 reload readback", v, 32'd3);
        step(6);
        rd(ra(1, 1), v);
        chk("R5 reaches zero", v, 32'd0);
        step(1);
        rd(ra(1, 1), v);
        chk("R5 new value at reload", v, 32'd3);
        rd(ra(1, 3), v);
        chk("R5 R4 flag at reload", v, 32'd1);
        clr(1);

        // R6 restart by enable toggle
        wr(ra(3, 0), 32'd8);
        wr(ra(3, 2), 32'h1);
        step(3);
        wr(ra(3, 2), 32'h0);
        rd(ra(3, 1), v);
        chk("R6 count after disable", v, 32'd5);
        wr(ra(3, 2), 32'h1);
        rd(ra(3, 1), v);
        chk("R6 count held while off", v, 32'd5);
        step(1);
        rd(ra(3, 1), v);
        chk("R6 restart from reload", v, 32'd8);
        clr(3);

        // R11 writes to live count ignored
        wr(ra(2, 0), 32'd20);
        wr(ra(2, 2), 32'h1);
        step(1);
        wr(ra(2, 1), 32'd5);
        rd(ra(2, 1), v);
        chk("R11 count write ignored", v, 32'd19);
        clr(2);

        // R7 clear colliding with a wrap, then write of zero
        wr(ra(2, 0), 32'd3);
        wr(ra(2, 2), 32'h1);
        step(4);
        wr(ra(2, 3), 32'd1);
        rd(ra(2, 3), v);
        chk("R7 set beats clear", v, 32'd1);
        rd(ra(2, 1), v);
        chk("R4 reload on wrap", v, 32'd3);
        wr(ra(2, 3), 32'd1);
        rd(ra(2, 3), v);
        chk("R7 clear by one", v, 32'd0);
        step(3);
        wr(ra(2, 3), 32'd0);
        rd(ra(2, 3), v);
        chk("R7 write zero keeps flag", v, 32'd1);
        clr(2);

        // R9 module disable
        wr(ra(0, 0), 32'd50);
        wr(ra(0, 2), 32'h1);
        step(5);
        wr(12'h000, 32'h2);
        rd(ra(0, 1), v);
        chk("R9 count at disable", v, 32'd45);
        rd(ra(1, 1), p1);
        wr(ra(1, 0), 32'd9);
        wr(ra(1, 2), 32'h1);
        step(3);
        rd(ra(0, 1), v);
        chk("R9 frozen count", v, 32'd45);
        rd(ra(1, 1), v);
        chk("R9 no load on enable", v, p1);
        rd(12'h000, v);
        chk("R9 disable readback", v, 32'h2);
        wr(12'h000, 32'h0);
        rd(ra(0, 1), v);
        chk("R9 still frozen at release", v, 32'd45);
        step(1);
        rd(ra(0, 1), v);
        chk("R9 resumes counting", v, 32'd44);
        rd(ra(1, 1), v);
        chk("R9 deferred load", v, 32'd9);
        clr(0);
        clr(1);

        // R10 cascaded pairs
        cascade(1, 2, 1);
        cascade(2, 1, 2);
        cascade(3, 3, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule